// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with DMA Tenure Control

This block decides which of three masters owns a shared on-chip bus in each clock cycle. The masters are a DMA engine, a system-management master and the CPU. The CPU ranks lowest and also takes the bus when no one asks for it. The grant is registered, so a change on the request inputs shows on the grant one clock edge later.

The DMA engine works in one of two tenure styles. In block style it keeps the bus, without a break, for a programmed number of beats. In packet style it lets the CPU in on every other cycle whenever the CPU is waiting. A configuration register written through a simple write port holds a promotion enable. When that enable is set, a CPU that raises its fast-interrupt line while requesting takes the bus ahead of everything, including a block tenure that is in progress. The tenure keeps its remaining beats and picks up again once the promotion ends.

Top module: `bus_prio_arbiter`

## Requirements
- R1: Exactly one bit of `gnt_o` is set in every cycle. The encoding is bit 0 for DMA, bit 1 for system-management and bit 2 for CPU. During and straight after reset the CPU holds the grant and `busy_o` is 0.
- R2: Outside any tenure, yield or promotion, the grant one edge after the requests are applied goes to DMA if it requests. Otherwise it goes to system-management if that requests, and otherwise to the CPU.
- R3: A block tenure starts when DMA is granted while `dma_block_i`=1. It gives DMA `dma_count_i` consecutive beats, with a count of 0 treated as 1. This happens whatever the other requests are and even if `dma_req_i` drops. `busy_o` is 1 in exactly the cycles of the tenure.
- R4: In packet mode, after a DMA beat with both `dma_req_i` and `cpu_req_i` high, the next cycle goes to the CPU. The two masters then alternate.
- R5: In packet mode with no CPU request, DMA keeps the bus on back-to-back cycles with no gaps.
- R6: With configuration bit 1 set, `cpu_fiq_i`=1 together with `cpu_req_i`=1 grants the CPU on the next edge, over any other request or tenure.
- R7: A block tenure preempted by promotion keeps its remaining beat count. It resumes with DMA once promotion ends, and `busy_o` stays 1 across the preempted cycles.
- R8: The configuration register resets to 0. While bit 1 is 0, `cpu_fiq_i` has no effect on the grant. The other configuration bits have no effect on the grant.
- R9: `dma_block_i` and `dma_count_i` are sampled only when a tenure starts. Changing them mid-tenure does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_req_i | input | 1 | DMA bus request |
| sys_req_i | input | 1 | System-management bus request |
| cpu_req_i | input | 1 | CPU bus request |
| dma_block_i | input | 1 | 1 = block tenure, 0 = packet tenure |
| dma_count_i | input | CNT_W | Beats in a block tenure |
| cpu_fiq_i | input | 1 | CPU fast interrupt |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| gnt_o | output | 3 | One-hot grant {cpu, sys, dma} |
| busy_o | output | 1 | Block tenure in progress |

## Verification
The bench sweeps block counts from 0 through 6 while both other masters request, and measures the length of the DMA run. An off-by-one counter would give one beat too many or too few, and mishandling a count of 0 would lock the bus. Packet runs check that the grant strictly alternates when the CPU waits and never gaps when it does not. A design that skipped the yield would starve the CPU, and one that yielded on every beat would leave idle gaps. The promotion tests preempt a six-beat block mid-way and count the DMA beats across the break. A design that restarted or dropped the count would give a run length other than six, or would lower `busy_o` during the preemption.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int NM = 3;
  localparam int M_DMA = 0;
  localparam int M_SYS = 1;
  localparam int M_CPU = 2;
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/arb_dma_tenure.sv
module arb_dma_tenure #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             active_o,
  output logic             hold_o
);
  logic [CNT_W-1:0] rem_q;
  logic             active_q;
  logic [CNT_W-1:0] load_val;
  logic             last_beat;

  assign load_val  = (count_i == '0) ? CNT_W'(1) : count_i;
  assign last_beat = active_q && beat_i && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      rem_q    <= load_val;
      active_q <= 1'b1;
    end else if (active_q && beat_i) begin
      rem_q <= rem_q - CNT_W'(1);
      if (last_beat) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign hold_o   = active_q && !last_beat;

  a_r3_rem_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (rem_q != '0));
  a_r7_rem_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !beat_i && !start_i) |=> $stable(rem_q));
endmodule

// File: rtl/arb_grant_sel.sv
module arb_grant_sel
  import bus_arb_pkg::*;
(
  input  logic [NM-1:0] req_i,
  input  logic          promo_i,
  input  logic          hold_i,
  input  logic          yield_i,
  output logic [NM-1:0] nxt_o
);
  always_comb begin
    nxt_o = '0;
    if (promo_i || yield_i) begin
      nxt_o[M_CPU] = 1'b1;
    end else if (hold_i) begin
      nxt_o[M_DMA] = 1'b1;
    end else begin
      nxt_o[M_CPU] = 1'b1;
      for (int i = NM - 1; i >= 0; i--) begin
        if (req_i[i]) begin
          nxt_o    = '0;
          nxt_o[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
  import bus_arb_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CFG_W     = 8,
  parameter int PROMO_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_req_i,
  input  logic             sys_req_i,
  input  logic             cpu_req_i,
  input  logic             dma_block_i,
  input  logic [CNT_W-1:0] dma_count_i,
  input  logic             cpu_fiq_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [NM-1:0]    gnt_o,
  output logic             busy_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [NM-1:0]    gnt_q, nxt, req;
  logic             promo, pkt_yield, blk_active, blk_hold, blk_start;

  assign req = {cpu_req_i, sys_req_i, dma_req_i};

  arb_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .cfg_o(cfg_q)
  );

  assign promo     = cfg_q[PROMO_BIT] && cpu_fiq_i && cpu_req_i;
  // packet beat just ended and the CPU waits: hand over for one cycle
  assign pkt_yield = gnt_q[M_DMA] && !blk_active && dma_req_i && cpu_req_i;
  assign blk_start = nxt[M_DMA] && !blk_hold && dma_block_i;

  arb_dma_tenure #(.CNT_W(CNT_W)) u_ten (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(blk_start),
    .beat_i(gnt_q[M_DMA]), .count_i(dma_count_i),
    .active_o(blk_active), .hold_o(blk_hold)
  );

  arb_grant_sel u_sel (
    .req_i(req), .promo_i(promo), .hold_i(blk_hold),
    .yield_i(pkt_yield), .nxt_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= NM'(1) << M_CPU;
    else         gnt_q <= nxt;
  end

  assign gnt_o  = gnt_q;
  assign busy_o = blk_active;

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == 1);
  a_r6_promo_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promo |=> gnt_o[M_CPU]);
  a_r4_pkt_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o[M_DMA] && !busy_o && dma_req_i && cpu_req_i) |=> gnt_o[M_CPU]);
  a_r3_busy_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (gnt_o[M_DMA] || gnt_o[M_CPU]));
  a_r5_pkt_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_i && !cpu_req_i) |=> gnt_o[M_DMA]);
endmodule

// File: tb/sim_bus_prio_arbiter.sv
module sim_bus_prio_arbiter;
  localparam logic [2:0] G_DMA = 3'b001, G_SYS = 3'b010, G_CPU = 3'b100;

  logic clk = 0, rst_ni = 0;
  logic dma_req = 0, sys_req = 0, cpu_req = 0, dma_block = 0, fiq = 0, cfg_we = 0;
  logic [7:0] dma_count = 0, cfg_wdata = 0;
  logic [2:0] gnt;
  logic busy;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_prio_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dma_req_i(dma_req), .sys_req_i(sys_req),
    .cpu_req_i(cpu_req), .dma_block_i(dma_block), .dma_count_i(dma_count),
    .cpu_fiq_i(fiq), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .gnt_o(gnt), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dma_req = 0; sys_req = 0; cpu_req = 0; fiq = 0; dma_block = 0;
    step(); step();
  endtask

  task automatic wr_cfg(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    step();
    cfg_we = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int run, cpu_n;
    logic busy_ok;
    @(negedge clk); @(negedge clk);
    chk("R1 reset grant", gnt, G_CPU);
    chk("R1 reset busy", busy, 0);
    rst_ni = 1;
    step();
    chk("R1 idle grant", gnt, G_CPU);

    // R2 priority sweep over all request combos
    for (int m = 0; m < 8; m++) begin
      idle();
      dma_req = m[0]; sys_req = m[1]; cpu_req = m[2];
      step();
      chk("R2 priority", gnt, m[0] ? G_DMA : (m[1] ? G_SYS : G_CPU));
    end

    // R3/R9 block sweep
    for (int c = 0; c < 7; c++) begin
      idle();
      dma_req = 1; sys_req = 1; cpu_req = 1; dma_block = 1; dma_count = 8'(c);
      step();
      chk("R3 block start", gnt, G_DMA);
      dma_req = 0; dma_block = 0; dma_count = 8'd50; // R9 ignored mid-tenure
      run = 1; busy_ok = busy;
      for (int k = 0; k < 20; k++) begin
        step();
        if (gnt != G_DMA) break;
        run++;
        busy_ok &= busy;
      end
      chk("R3 block length", run, (c == 0) ? 1 : c);
      chk("R3 busy during tenure", busy_ok, 1);
      chk("R3 after tenure grant", gnt, G_SYS);
      chk("R3 busy after tenure", busy, 0);
    end

    // R4 packet alternation
    idle();
    dma_req = 1; cpu_req = 1; sys_req = 1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R4 packet alternate", gnt, (k % 2 == 0) ? G_DMA : G_CPU);
    end
    // R5 back-to-back packet beats
    idle();
    dma_req = 1; sys_req = 1;
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R5 packet stream", gnt, G_DMA);
    end

    // R8 promotion off after reset and with other bits set
    idle();
    sys_req = 1; cpu_req = 1; fiq = 1;
    step();
    chk("R8 no promo at reset", gnt, G_SYS);
    wr_cfg(8'hFD);
    step();
    chk("R8 other cfg bits inert", gnt, G_SYS);
    // R6 promotion
    wr_cfg(8'h02);
    step();
    chk("R6 promo over sys", gnt, G_CPU);
    dma_req = 1;
    step();
    chk("R6 promo over dma", gnt, G_CPU);

    // R7 preempted block resumes with remaining count
    idle();
    dma_req = 1; dma_block = 1; dma_count = 8'd6; sys_req = 1;
    step(); // beat 1
    dma_req = 0;
    step(); // beat 2
    chk("R7 pre beat", gnt, G_DMA);
    cpu_req = 1; fiq = 1;
    cpu_n = 0; busy_ok = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      if (gnt == G_CPU) cpu_n++;
      busy_ok &= busy;
    end
    chk("R7 preempt cycles", cpu_n, 3);
    chk("R7 busy held", busy_ok, 1);
    fiq = 0; cpu_req = 0;
    run = 2;
    for (int k = 0; k < 20; k++) begin
      step();
      if (gnt != G_DMA) break;
      run++;
    end
    chk("R7 total beats", run, 6);
    chk("R7 tenure end", busy, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule